// File: doc/BRIEF.md
# Bipolar Line Decoder with Alternation Check

This block sits behind a line receiver that has already sliced a bipolar return-to-zero signal into two logic rails, one high for a positive pulse and one high for a negative pulse. Once per bit slot, close to the middle of the slot where the half-width pulse is surest to be present, an external timing circuit raises a sample strobe. On each strobe the block turns the rails into a data bit: a pulse of either polarity is a one, and no pulse is a zero.

The block also remembers the polarity of the last pulse it accepted. Correct line coding makes every pulse the opposite polarity of the one before it, so a pulse that repeats the previous polarity is flagged as a bipolar violation. This holds however many zeros lie between the two pulses. Violations are counted in a saturating counter. A sample with both rails high is not a legal symbol. It decodes as a one, raises a separate flag and leaves the polarity memory untouched. The check finds only some line errors. For example, losing a pair of adjacent pulses from an alternating run keeps the survivors alternating, and nothing is reported.

Top module: `ami_rx_decoder`

## Requirements
- R1: While reset is asserted (rstN low) and in the cycle after it is released, bitOut, bitValid, violPulse and illegalPulse are 0 and violCount is 0.
- R2: A strobe sampled at a clock edge makes bitValid high for exactly the following cycle. bitOut in that cycle is 1 when either rail was high and 0 otherwise.
- R3: A strobe with both rails low gives bitOut 0, no violation and no change to the polarity memory.
- R4: The first single-rail pulse after reset never raises violPulse, and a pulse whose polarity is the opposite of the previous accepted pulse never raises it either.
- R5: A single-rail pulse with the same polarity as the previous accepted pulse raises violPulse for one cycle, together with its bitValid, even if zeros were sampled in between.
- R6: After a violation the remembered polarity is that of the pulse just received. So positive, positive, negative gives one violation, and three positives in a row give two.
- R7: A strobe with both rails high gives bitOut 1 and raises illegalPulse for one cycle. violPulse stays low and the polarity memory is left unchanged.
- R8: violCount rises by one in the same cycle as each violPulse, and it holds at its all-ones maximum (15 for the default 4-bit width) once reached.
- R9: Without a strobe, the rail inputs have no effect. bitValid, violPulse and illegalPulse stay low, and the polarity memory and the counter keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Mid-slot sample strobe, one cycle per bit slot |
| railP | input | 1 | Positive-pulse rail level |
| railN | input | 1 | Negative-pulse rail level |
| bitOut | output | 1 | Decoded data bit |
| bitValid | output | 1 | One-cycle qualifier for bitOut |
| violPulse | output | 1 | One-cycle bipolar violation flag |
| illegalPulse | output | 1 | One-cycle flag for both rails high |
| violCount | output | CNT_W | Saturating violation count |

## Verification
The assertions assume that the rails and the strobe always carry known 0/1 values and that reset is applied before the first strobe. They also assume that every strobe is a separate decision, even when strobes come on back-to-back cycles. The stimulus changes inputs only on the falling clock edge, holds reset for several cycles at the start, and gives only defined levels. It includes back-to-back strobes, gaps without a strobe that carry rail activity, and long runs of same-polarity pulses that drive the counter into saturation.

// File: rtl/ami_rx_pkg.sv
package ami_rx_pkg;

  // Polarity encoding: 1 = positive rail, 0 = negative rail
  typedef struct packed {
    logic takeBit;
    logic markBit;
    logic loadRef;
    logic newPol;
    logic raiseViol;
    logic raiseIllegal;
  } ctlStrobes_t;

  typedef struct packed {
    logic refValid;
    logic refPol;
  } refState_t;

endpackage

// File: rtl/ami_rx_ctrl.sv
module ami_rx_ctrl
  import ami_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleEn,
  input  logic        railP,
  input  logic        railN,
  input  refState_t   refState,
  output ctlStrobes_t strb
);

  logic onlyP;
  logic onlyN;
  logic single;
  logic sameAsRef;

  always_comb begin
    onlyP     = railP & ~railN;
    onlyN     = railN & ~railP;
    single    = onlyP | onlyN;
    sameAsRef = refState.refValid & (refState.refPol == onlyP);

    strb.takeBit      = sampleEn;
    strb.markBit      = railP | railN;
    strb.loadRef      = sampleEn & single;
    strb.newPol       = onlyP;
    strb.raiseViol    = sampleEn & single & sameAsRef;
    strb.raiseIllegal = sampleEn & railP & railN;
  end

  // R4: with no reference yet, no violation may be requested
  a_r4_first_no_viol: assert property (@(posedge clk) disable iff (!rstN)
    !refState.refValid |-> !strb.raiseViol);

  // R7: an illegal symbol never also counts as a violation
  a_r7_illegal_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.raiseIllegal && strb.raiseViol));

endmodule

// File: rtl/ami_rx_dpath.sv
module ami_rx_dpath
  import ami_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  output refState_t        refState,
  output logic             bitOut,
  output logic             bitValid,
  output logic             violPulse,
  output logic             illegalPulse,
  output logic [CNT_W-1:0] violCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refState     <= '0;
      bitOut       <= 1'b0;
      bitValid     <= 1'b0;
      violPulse    <= 1'b0;
      illegalPulse <= 1'b0;
      violCount    <= '0;
    end else begin
      bitValid     <= strb.takeBit;
      violPulse    <= strb.raiseViol;
      illegalPulse <= strb.raiseIllegal;
      if (strb.takeBit) bitOut <= strb.markBit;
      if (strb.loadRef) begin
        refState.refValid <= 1'b1;
        refState.refPol   <= strb.newPol;
      end
      if (strb.raiseViol && (violCount != CNT_MAX))
        violCount <= violCount + CNT_ONE;
    end
  end

  // R2: valid follows each strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeBit |=> bitValid);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.takeBit |=> !bitValid);

  // R8: counter holds once saturated
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (violCount == CNT_MAX) |=> (violCount == CNT_MAX));

  // R8: any counter change coincides with a violation flag and is a step of one
  a_r8_step_one: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(violCount) |-> (violPulse && (violCount == $past(violCount) + CNT_ONE)));

  // R9: without a strobe the polarity memory holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.takeBit |=> $stable(refState));

endmodule

// File: rtl/ami_rx_decoder.sv
module ami_rx_decoder
  import ami_rx_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic             railP,
  input  logic             railN,
  output logic             bitOut,
  output logic             bitValid,
  output logic             violPulse,
  output logic             illegalPulse,
  output logic [CNT_W-1:0] violCount
);

  ctlStrobes_t strb;
  refState_t   refState;

  ami_rx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .railP    (railP),
    .railN    (railN),
    .refState (refState),
    .strb     (strb)
  );

  ami_rx_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .refState     (refState),
    .bitOut       (bitOut),
    .bitValid     (bitValid),
    .violPulse    (violPulse),
    .illegalPulse (illegalPulse),
    .violCount    (violCount)
  );

endmodule

// File: tb/ami_rx_decoder_tb.sv
module ami_rx_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic railP = 1'b0;
  logic railN = 1'b0;
  logic bitOut, bitValid, violPulse, illegalPulse;
  logic [CNT_W-1:0] violCount;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit compareOn = 1'b0;
  int cycles = 0;

  // reference model state
  int mRefValid = 0, mRefPol = 0;
  int mBit = 0, mValid = 0, mViol = 0, mIll = 0, mCount = 0;
  int markSeq[$];

  ami_rx_decoder #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .railP(railP), .railN(railN),
    .bitOut(bitOut), .bitValid(bitValid), .violPulse(violPulse),
    .illegalPulse(illegalPulse), .violCount(violCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  // behavioural reference: polarity as +1 / -1, 0 = no reference
  always @(posedge clk) begin
    if (!rstN) begin
      mRefValid = 0; mRefPol = 0; mBit = 0; mValid = 0; mViol = 0; mIll = 0; mCount = 0;
    end else begin
      mValid = sampleEn;
      mViol = 0;
      mIll = 0;
      if (sampleEn) begin
        mBit = (railP || railN) ? 1 : 0;
        if (railP && railN) mIll = 1;
        else if (railP || railN) begin
          int pol;
          pol = railP ? 1 : -1;
          if (mRefValid != 0 && mRefPol == pol) begin
            mViol = 1;
            if (mCount < CNT_MAX) mCount++;
          end
          mRefValid = 1;
          mRefPol = pol;
          markSeq.push_back(pol);
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (compareOn) begin
      chk("R2", "bitValid", int'(bitValid), mValid);
      if (mValid != 0) chk(curReq, "bitOut", int'(bitOut), mBit);
      chk(curReq, "violPulse", int'(violPulse), mViol);
      chk("R7", "illegalPulse", int'(illegalPulse), mIll);
      chk("R8", "violCount", int'(violCount), mCount);
    end
  end

  // one strobed slot: 1 = positive, -1 = negative, 0 = space, 2 = both rails
  task automatic slot(int sym);
    @(negedge clk);
    sampleEn = 1'b1;
    railP = (sym == 1 || sym == 2);
    railN = (sym == -1 || sym == 2);
  endtask

  task automatic idle(int n, bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleEn = 1'b0;
      railP = noise ? 1'b1 : 1'b0;
      railN = (noise && (i % 2 == 1)) ? 1'b1 : 1'b0;
    end
  endtask

  initial begin
    int c0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "bitValid in reset", int'(bitValid), 0);
    chk("R1", "violCount in reset", int'(violCount), 0);
    chk("R1", "violPulse in reset", int'(violPulse), 0);
    chk("R1", "illegalPulse in reset", int'(illegalPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "bitOut after release", int'(bitOut), 0);
    compareOn = 1'b1;

    // R4: first pulse then strict alternation, back to back
    curReq = "R4";
    slot(1); slot(-1); slot(1); slot(-1); idle(1, 0);
    @(negedge clk);
    chk("R4", "count after alternation", int'(violCount), 0);

    // R3: spaces between alternating pulses
    curReq = "R3";
    slot(0); slot(0); slot(1); slot(0); slot(-1); idle(2, 0);

    // R5: same polarity across zeros
    curReq = "R5";
    slot(0); slot(0); slot(-1); idle(1, 0);
    @(negedge clk);
    chk("R5", "count after repeat across zeros", int'(violCount), 1);

    // R6: reference follows the violating pulse
    curReq = "R6";
    c0 = int'(violCount);
    slot(1); slot(1); slot(-1); idle(1, 0);
    @(negedge clk);
    chk("R6", "P,P,N gives one violation", int'(violCount) - c0, 1);
    c0 = int'(violCount);
    slot(1); slot(1); slot(1); idle(1, 0);
    @(negedge clk);
    chk("R6", "P,P,P gives two violations", int'(violCount) - c0, 2);

    // R7: both rails high leaves the reference (positive) alone
    curReq = "R7";
    c0 = int'(violCount);
    slot(2); idle(1, 0);
    @(negedge clk);
    chk("R7", "illegal bit decodes one", int'(bitOut), 1);
    slot(-1); idle(1, 0);
    @(negedge clk);
    chk("R7", "no violation after illegal then N", int'(violCount) - c0, 0);

    // R9: rail activity without a strobe is ignored
    curReq = "R9";
    c0 = int'(violCount);
    idle(6, 1);
    @(negedge clk);
    sampleEn = 1'b0; railP = 1'b0; railN = 1'b0;
    chk("R9", "count unchanged without strobe", int'(violCount), c0);
    slot(1); idle(1, 0);
    @(negedge clk);
    chk("R9", "reference was still negative", int'(violCount), c0);

    // R8: drive into saturation
    curReq = "R8";
    for (int i = 0; i < CNT_MAX + 5; i++) begin
      slot(1);
      if (i % 3 == 0) idle(1, 0);
    end
    idle(2, 0);
    @(negedge clk);
    chk("R8", "saturated count", int'(violCount), CNT_MAX);

    // R2: mixed pattern
    curReq = "R2";
    slot(0); slot(-1); slot(0); slot(1); slot(2); slot(0); idle(3, 0);

    compareOn = 1'b0;
    finishRun();
  end

endmodule